// File: doc/BRIEF.md
# Receive Interrupt Coalescing Timer

This block sits between a receive DMA engine and an interrupt status register and throttles receive-done interrupts. The DMA engine pulses `pkt_done_i` once for every packet it has finished writing to memory. Instead of raising one interrupt per packet, the block accumulates packets and issues a single-cycle `irq_o` pulse when either a configured number of packets has collected or a configured amount of time has elapsed, whichever is reached first.

Time is measured in coarse units. A free-running prescaler of `PRE_W` bits (2048 clock cycles at the default) divides the bus clock, and a unit counter counts prescaler wraps. Both run only while at least one packet is waiting for an interrupt. Every interrupt clears the packet count, the prescaler and the unit counter together, so each new coalescing window starts from zero. A packet threshold of 0 or 1 turns coalescing off, and a time threshold of 0 turns the timeout path off.

Top module: `rx_irq_blanker`

## Requirements
- R1: While `rst` is high and in the cycle after it is released with no packet, `irq_o` is 0 and no packet is pending.
- R2: With packet threshold N (`cfg_i[8:0]`, N >= 2) and the time field zero, `irq_o` goes high in the cycle after the clock edge that samples the N-th pending packet, and not earlier.
- R3: With a packet threshold of 0 or 1, every sampled packet produces `irq_o` high in the following cycle.
- R4: With time threshold T (`cfg_i[19:12]`, T >= 1) and fewer than N packets pending, `irq_o` goes high exactly 2048*T cycles after the edge that sampled the first pending packet.
- R5: A time field of 0 disables the timeout, so pending packets below the packet threshold never raise `irq_o`, however long they wait.
- R6: `irq_o` never rises unless a packet was pending or arriving in the previous cycle, however long the block sits idle.
- R7: After each interrupt the packet count and the elapsed-time count both restart from zero: earlier packets do not count toward the next interrupt, and the next timeout is measured from the first packet after the interrupt.
- R8: Configuration bits outside `cfg_i[8:0]` and `cfg_i[19:12]` have no effect on `irq_o`.
- R9: `irq_o` is high for one cycle per interrupt when no further packet follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_done_i | input | 1 | One-cycle pulse for each completed received packet |
| cfg_i | input | 32 | Configuration word: packet threshold in [8:0], time threshold in [19:12] |
| irq_o | output | 1 | Receive-done interrupt pulse |

## Verification
A packet counter that fails to clear shows as an interrupt after too few packets in the following window, visible one cycle after the early packet is sampled. A prescaler or unit counter that keeps its state across an interrupt, or that runs while nothing is pending, shifts the timeout edge. The bench pins that edge to the exact cycle 2048*T after the first packet, so any such error appears on the edge it should not, one unit or a few cycles early. A bad field decode shows on the first packet of the affected pattern, either as a missing pulse or as an extra one.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    localparam int CFG_W    = 32;
    localparam int PKT_W    = 9;
    localparam int TIME_W   = 8;
    localparam int PKT_LSB  = 0;
    localparam int TIME_LSB = 12;

    typedef struct packed {
        logic [PKT_W-1:0]  pkt_thr;
        logic [TIME_W-1:0] time_thr;
    } blank_cfg_t;

    function automatic blank_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        blank_cfg_t c;
        c.pkt_thr  = w[PKT_LSB +: PKT_W];
        c.time_thr = w[TIME_LSB +: TIME_W];
        return c;
    endfunction

    // A threshold of zero behaves like one: fire on every packet.
    function automatic logic [PKT_W-1:0] eff_pkt_thr(input logic [PKT_W-1:0] t);
        return (t == '0) ? PKT_W'(1) : t;
    endfunction

endpackage

// File: rtl/rxb_pkt_counter.sv
module rxb_pkt_counter
    import rxb_pkg::*;
#(
    parameter int CW = PKT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pkt_i,
    input  logic          clr_i,
    input  logic [CW-1:0] thr_i,
    output logic          hit_o,
    output logic          pending_o
);
    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;
    logic [CW-1:0] thr_eff;

    always_comb begin
        thr_eff = (thr_i == '0) ? CW'(1) : thr_i;
        if (pkt_i && cnt_q != CMAX) cnt_nx = cnt_q + CW'(1);
        else                        cnt_nx = cnt_q;
        hit_o = (cnt_nx != '0) && (cnt_nx >= thr_eff);
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) cnt_q <= '0;
        else              cnt_q <= cnt_nx;
    end

    assign pending_o = (cnt_q != '0);

endmodule

// File: rtl/rxb_time_counter.sv
module rxb_time_counter
    import rxb_pkg::*;
#(
    parameter int PW = 11,
    parameter int TW = TIME_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    input  logic          clr_i,
    input  logic [TW-1:0] thr_i,
    output logic          hit_o
);
    localparam logic [TW-1:0] TMAX = '1;

    logic [PW-1:0] pre_q;
    logic [TW-1:0] unit_q;
    logic          wrap;
    logic [TW:0]   unit_inc;

    always_comb begin
        wrap     = &pre_q;
        unit_inc = {1'b0, unit_q} + (TW+1)'(1);
        hit_o    = run_i && (thr_i != '0) && wrap && (unit_inc >= {1'b0, thr_i});
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            pre_q  <= '0;
            unit_q <= '0;
        end else if (run_i) begin
            pre_q <= pre_q + PW'(1);
            if (wrap && unit_q != TMAX) unit_q <= unit_q + TW'(1);
        end
    end

endmodule

// File: rtl/rx_irq_blanker.sv
module rx_irq_blanker
    import rxb_pkg::*;
#(
    parameter int PRE_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pkt_done_i,
    input  logic [CFG_W-1:0] cfg_i,
    output logic             irq_o
);
    blank_cfg_t cfg;
    logic       pkt_hit;
    logic       time_hit;
    logic       pend_any;
    logic       fire;
    logic       irq_q;
    logic       cfg_unused;

    assign cfg        = decode_cfg(cfg_i);
    assign cfg_unused = ^{cfg_i[CFG_W-1:TIME_LSB+TIME_W], cfg_i[TIME_LSB-1:PKT_LSB+PKT_W]};

    rxb_pkt_counter #(.CW(PKT_W)) u_pkt (
        .clk      (clk),
        .rst      (rst),
        .pkt_i    (pkt_done_i),
        .clr_i    (fire),
        .thr_i    (cfg.pkt_thr),
        .hit_o    (pkt_hit),
        .pending_o(pend_any)
    );

    rxb_time_counter #(.PW(PRE_W), .TW(TIME_W)) u_time (
        .clk   (clk),
        .rst   (rst),
        .run_i (pend_any),
        .clr_i (fire),
        .thr_i (cfg.time_thr),
        .hit_o (time_hit)
    );

    assign fire = pkt_hit || time_hit;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= fire;
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/rxb_chk.sv
module rxb_chk
    import rxb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pkt_done_i,
    input logic [CFG_W-1:0] cfg_i,
    input logic             pend_any,
    input logic             irq_o
);
    // R6
    irq_needs_cause_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ($past(pkt_done_i) || $past(pend_any)));

    // R7
    irq_clears_pending_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> !pend_any);

    // R3
    single_pkt_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_done_i && (cfg_i[PKT_LSB +: PKT_W] <= PKT_W'(1))) |=> irq_o);

    // R5
    no_timeout_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!pkt_done_i && $stable(cfg_i) && (cfg_i[TIME_LSB +: TIME_W] == '0)) |=> !irq_o);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!irq_o && !pend_any));
endmodule

bind rx_irq_blanker rxb_chk u_rxb_chk (
    .clk       (clk),
    .rst       (rst),
    .pkt_done_i(pkt_done_i),
    .cfg_i     (cfg_i),
    .pend_any  (pend_any),
    .irq_o     (irq_o)
);

// File: tb/rx_irq_blanker_tb.sv
module rx_irq_blanker_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt = 1'b0;
    logic [31:0] cfg = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rx_irq_blanker dut_i (
        .clk       (clk),
        .rst       (rst),
        .pkt_done_i(pkt),
        .cfg_i     (cfg),
        .irq_o     (irq)
    );

    // {cfg[31:0], packets[7:0], expected irqs[7:0]}; time field zero, R8 rows carry junk bits
    localparam int NV = 7;
    localparam logic [47:0] VEC [NV] = '{
        {32'h0000_0003, 8'd9, 8'd3},
        {32'h0000_0004, 8'd9, 8'd2},
        {32'h0000_0000, 8'd5, 8'd5},
        {32'h0000_0001, 8'd4, 8'd4},
        {32'h0000_0002, 8'd7, 8'd3},
        {32'hFFF0_0E03, 8'd9, 8'd3},
        {32'hABC0_0C05, 8'd11, 8'd2}
    };

    function automatic logic [31:0] mk(input int p, input int t);
        return (32'(t) << 12) | 32'(p);
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: irq_o=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: count=%0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; pkt = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Packet sampled at the next edge; returns at the negedge after it.
    task automatic send_pkt();
        pkt = 1'b1;
        @(negedge clk);
        pkt = 1'b0;
    endtask

    task automatic idle(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq) seen++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int seen;
        @(negedge clk);
        do_reset();
        // R1: quiet after reset
        check(irq, 1'b0, "R1");
        @(negedge clk);
        check(irq, 1'b0, "R1");

        // Table walk: R2, R3, R8
        for (int v = 0; v < NV; v++) begin
            int cnt;
            int n;
            do_reset();
            cfg = VEC[v][47:16];
            n   = int'(VEC[v][15:8]);
            cnt = 0;
            for (int k = 0; k < n; k++) begin
                send_pkt();
                if (irq) cnt++;
                idle(1, seen);
                cnt += seen;
            end
            idle(4, seen);
            cnt += seen;
            check_int(cnt, int'(VEC[v][7:0]), (v >= 5) ? "R8" : "R2/R3");
        end

        // R2: exact cycle of the threshold pulse, R9 width
        do_reset();
        cfg = mk(3, 0);
        send_pkt(); check(irq, 1'b0, "R2");
        send_pkt(); check(irq, 1'b0, "R2");
        send_pkt(); check(irq, 1'b1, "R2");
        @(negedge clk); check(irq, 1'b0, "R9");

        // R3: threshold 0 fires on a lone packet next cycle
        do_reset();
        cfg = mk(0, 0);
        send_pkt(); check(irq, 1'b1, "R3");
        @(negedge clk); check(irq, 1'b0, "R9");

        // R4: time threshold 1 -> 2048 cycles after first packet edge
        do_reset();
        cfg = mk(5, 1);
        send_pkt();
        idle(2047, seen); check_int(seen, 0, "R4");
        check(irq, 1'b0, "R4");
        @(negedge clk); check(irq, 1'b1, "R4");
        @(negedge clk); check(irq, 1'b0, "R9");

        // R4: time threshold 2 -> 4096 cycles
        do_reset();
        cfg = mk(5, 2);
        send_pkt();
        idle(4095, seen); check_int(seen, 0, "R4");
        @(negedge clk); check(irq, 1'b1, "R4");

        // R6: idle with timeout enabled never fires
        do_reset();
        cfg = mk(5, 1);
        idle(5000, seen); check_int(seen, 0, "R6");

        // R5: timeout off, pending packet waits for the packet threshold
        do_reset();
        cfg = mk(5, 0);
        send_pkt();
        idle(5000, seen); check_int(seen, 0, "R5");
        for (int k = 0; k < 3; k++) send_pkt();
        check(irq, 1'b0, "R5");
        send_pkt(); check(irq, 1'b1, "R5");

        // R7: packet count restarts after an interrupt
        do_reset();
        cfg = mk(3, 0);
        send_pkt(); send_pkt(); send_pkt();
        check(irq, 1'b1, "R7");
        send_pkt(); send_pkt();
        check(irq, 1'b0, "R7");
        idle(3, seen); check_int(seen, 0, "R7");
        send_pkt(); check(irq, 1'b1, "R7");

        // R7: time count restarts after an interrupt
        do_reset();
        cfg = mk(2, 1);
        send_pkt();
        idle(1000, seen); check_int(seen, 0, "R7");
        send_pkt(); check(irq, 1'b1, "R7");
        idle(5, seen);
        send_pkt();
        idle(2047, seen); check_int(seen, 0, "R7");
        @(negedge clk); check(irq, 1'b1, "R7");

        finish_run();
    end

endmodule